// File: doc/BRIEF.md
# Quad Texel Fetch Conflict Serializer

This block sits between the four pixel lanes of a 2x2 quad and a texture cache that returns one whole 4x4 texel tile per read. Each cycle it can accept one group of four texel addresses. Each address is a mip level plus u and v coordinates. The block then works out how many cache read cycles the group needs.

When the four texels lie in one tile of one mip level, as in ordinary bilinear mipmapped sampling, a single read serves all four lanes. When the lanes scatter, as with lookup-table fetches, the block issues one read per distinct tile. Every lane that shares the tile being read is served in the same cycle. A fully scattered quad therefore costs four reads, and that factor depends only on how the addresses relate to each other.

The cache is modelled as a combinational read port: the tile number goes out, and sixteen texels come back in the same cycle. Results leave on four lane outputs with a one-cycle done strobe. A read-count output shows what each group cost.

Top module: `quad_fetch_serializer`

## Requirements
- R1: While reset is held and at the first clock after it, `in_ready` is 1, `rd_en` is 0, `out_done` is 0, `out_cycles` is 0 and every lane texel is 0.
- R2: A group is taken on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle through the last read cycle of that group, and 1 again in the done cycle.
- R3: The tile key of a lane is {lod, u[U_W-1:2], v[V_W-1:2]}. The number of read cycles for a group equals the number of distinct tile keys among its four lanes, so a coherent quad takes exactly one read.
- R4: Each read addresses the tile of the lowest-numbered lane not yet served. Tiles are therefore issued in order of first appearance from lane 0 to lane 3, and every unserved lane with that tile is served in that read.
- R5: `rd_en` is 1 in consecutive cycles, starting in the cycle after acceptance and ending at the last read. It is 0 at all other times.
- R6: A lane's result is the texel at bit offset {v[1:0],u[1:0]}*TEX_W of `rd_data`, taken in the read that served that lane.
- R7: `out_done` is a one-cycle pulse in the cycle after the last read. `out_texel` (lane i at bits i*TEX_W) holds the group's results from then until the next done pulse.
- R8: `out_cycles` equals the number of reads of the last finished group. It is updated with `out_done` and holds until the next one.
- R9: Lanes with equal u and v but different lod are in different tiles and take separate reads.
- R10: `in_valid` and the address inputs have no effect while `in_ready` is 0: no extra group is started and the results of the current group are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Block can take a group |
| in_lod | input | 4*LOD_W | Mip level per lane, lane i at bits i*LOD_W |
| in_u | input | 4*U_W | u coordinate per lane |
| in_v | input | 4*V_W | v coordinate per lane |
| rd_en | output | 1 | Cache read strobe |
| rd_tile | output | TILE_W | Tile key being read |
| rd_data | input | 16*TEX_W | Tile texels, index {v[1:0],u[1:0]} |
| out_done | output | 1 | Group results valid pulse |
| out_texel | output | 4*TEX_W | Lane results |
| out_cycles | output | 3 | Reads spent on the last group |

## Verification
A wrong pending-lane mask or leader choice shows up within the same group. An extra read appears, the read count does not match the number of distinct tiles, or a tile comes out of first-appearance order, and all of this is visible on `rd_tile` during the read cycles. A wrong texel index or a missed capture shows as a bad lane value in the done cycle, and a late or doubled done strobe breaks the fixed count of reads plus one cycle. Directed quads cover the single-tile case, the four-tile case, lod-only differences and interleaved sharing, and seeded random quads mix coherent, clustered and scattered groups.

// File: rtl/quad_fetch_serializer.sv
module quad_fetch_serializer #(
  parameter int LOD_W = 4,
  parameter int U_W   = 8,
  parameter int V_W   = 8,
  parameter int TEX_W = 8,
  localparam int TILE_W = LOD_W + (U_W - 2) + (V_W - 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [4*LOD_W-1:0]  in_lod,
  input  logic [4*U_W-1:0]    in_u,
  input  logic [4*V_W-1:0]    in_v,
  output logic                rd_en,
  output logic [TILE_W-1:0]   rd_tile,
  input  logic [16*TEX_W-1:0] rd_data,
  output logic                out_done,
  output logic [4*TEX_W-1:0]  out_texel,
  output logic [2:0]          out_cycles
);

  logic              busy;
  logic [3:0]        pend;
  logic [3:0]        match;
  logic [1:0]        lead;
  logic [2:0]        cnt;
  logic [TILE_W-1:0] tile_q [4];
  logic [3:0]        idx_q  [4];
  logic [TEX_W-1:0]  tex_q  [4];

  wire accept = in_valid && in_ready;

  assign in_ready = !busy;
  assign rd_en    = busy;
  assign rd_tile  = tile_q[lead];

  always_comb begin
    lead = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (pend[i]) lead = 2'(i);
    for (int i = 0; i < 4; i++)
      match[i] = pend[i] && (tile_q[i] == tile_q[lead]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend       <= 4'h0;
      cnt        <= 3'd0;
      out_done   <= 1'b0;
      out_cycles <= 3'd0;
      for (int i = 0; i < 4; i++) begin
        tile_q[i] <= '0;
        idx_q[i]  <= '0;
        tex_q[i]  <= '0;
      end
    end else begin
      out_done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        pend <= 4'hf;
        cnt  <= 3'd0;
        for (int i = 0; i < 4; i++) begin
          tile_q[i] <= {in_lod[i*LOD_W +: LOD_W], in_u[i*U_W+2 +: U_W-2], in_v[i*V_W+2 +: V_W-2]};
          idx_q[i]  <= {in_v[i*V_W +: 2], in_u[i*U_W +: 2]};
        end
      end else if (busy) begin
        cnt  <= cnt + 3'd1;
        pend <= pend & ~match;
        for (int i = 0; i < 4; i++)
          if (match[i]) tex_q[i] <= rd_data[idx_q[i]*TEX_W +: TEX_W];
        if ((pend & ~match) == 4'h0) begin
          busy       <= 1'b0;
          out_done   <= 1'b1;
          out_cycles <= cnt + 3'd1;
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_out
    assign out_texel[g*TEX_W +: TEX_W] = tex_q[g];
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  assert_reads_run_to_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_en || out_done));

  assert_done_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> ($past(rd_en) && !rd_en));

  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  assert_cycle_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_cycles >= 3'd1 && out_cycles <= 3'd4));

  assert_results_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !out_done |=> $stable(out_texel));

endmodule

// File: tb/test_quad_fetch_serializer.sv
module test_quad_fetch_serializer;
  localparam int LOD_W = 4, U_W = 8, V_W = 8, TEX_W = 8;
  localparam int TILE_W = LOD_W + U_W - 2 + V_W - 2;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic in_ready, rd_en, out_done;
  logic [4*LOD_W-1:0] in_lod = '0;
  logic [4*U_W-1:0]   in_u = '0;
  logic [4*V_W-1:0]   in_v = '0;
  logic [TILE_W-1:0]  rd_tile;
  logic [16*TEX_W-1:0] rd_data;
  logic [4*TEX_W-1:0] out_texel;
  logic [2:0] out_cycles;

  int n_checks = 0, n_fail = 0;
  logic [LOD_W-1:0] g_lod [4];
  logic [U_W-1:0]   g_u   [4];
  logic [V_W-1:0]   g_v   [4];

  always #4 clk = ~clk;

  quad_fetch_serializer #(.LOD_W(LOD_W), .U_W(U_W), .V_W(V_W), .TEX_W(TEX_W)) i_quad_fetch_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lod(in_lod), .in_u(in_u), .in_v(in_v), .rd_en(rd_en), .rd_tile(rd_tile),
    .rd_data(rd_data), .out_done(out_done), .out_texel(out_texel), .out_cycles(out_cycles));

  function automatic logic [TEX_W-1:0] texval(logic [TILE_W-1:0] t, logic [3:0] ix);
    return (t[7:0] ^ t[15:8]) + 8'(ix * 37) + 8'd5;
  endfunction

  always_comb
    for (int ix = 0; ix < 16; ix++) rd_data[ix*TEX_W +: TEX_W] = texval(rd_tile, 4'(ix));

  function automatic logic [TILE_W-1:0] key(int i);
    return {g_lod[i], g_u[i][U_W-1:2], g_v[i][V_W-1:2]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_group();
    for (int i = 0; i < 4; i++) begin
      in_lod[i*LOD_W +: LOD_W] = g_lod[i];
      in_u[i*U_W +: U_W] = g_u[i];
      in_v[i*V_W +: V_W] = g_v[i];
    end
  endtask

  task automatic run_group(bit junk);
    logic [TILE_W-1:0] et [4];
    int ne, n, order_bad, ready_bad;
    ne = 0;
    for (int i = 0; i < 4; i++) begin
      bit seen = 0;
      for (int j = 0; j < ne; j++) if (et[j] == key(i)) seen = 1;
      if (!seen) begin et[ne] = key(i); ne++; end
    end
    @(negedge clk);
    chk(in_ready == 1, "R2", "ready before group", int'(in_ready), 1);
    drive_group();
    in_valid = 1;
    @(negedge clk);
    in_valid = junk;
    n = 0; order_bad = 0; ready_bad = 0;
    for (int t = 0; t < 8; t++) begin
      if (junk) begin
        in_lod = 16'($urandom); in_u = $urandom; in_v = $urandom;
      end
      if (out_done) begin in_valid = 0; break; end
      if (rd_en) begin
        if (n < ne && rd_tile != et[n]) order_bad++;
        n++;
      end else order_bad++;
      if (in_ready) ready_bad++;
      @(negedge clk);
    end
    chk(out_done == 1, "R7", "done after last read", int'(out_done), 1);
    chk(rd_en == 0, "R5", "no read in done cycle", int'(rd_en), 0);
    chk(in_ready == 1, "R2", "ready back in done cycle", int'(in_ready), 1);
    chk(ready_bad == 0, "R2", "ready low cycles", ready_bad, 0);
    chk(n == ne, "R3", "read count", n, ne);
    chk(order_bad == 0, "R4", "tile order mismatches", order_bad, 0);
    chk(int'(out_cycles) == ne, "R8", "out_cycles", int'(out_cycles), ne);
    for (int i = 0; i < 4; i++) begin
      logic [TEX_W-1:0] e = texval(key(i), {g_v[i][1:0], g_u[i][1:0]});
      chk(out_texel[i*TEX_W +: TEX_W] == e, "R6", $sformatf("lane %0d texel", i),
          int'(out_texel[i*TEX_W +: TEX_W]), int'(e));
    end
    @(negedge clk);
    chk(out_done == 0, "R7", "done single pulse", int'(out_done), 0);
    chk(rd_en == 0 && in_ready == 1, "R10", "idle after group", int'(rd_en), 0);
    chk(int'(out_cycles) == ne, "R8", "out_cycles held", int'(out_cycles), ne);
    for (int i = 0; i < 4; i++) begin
      logic [TEX_W-1:0] e = texval(key(i), {g_v[i][1:0], g_u[i][1:0]});
      chk(out_texel[i*TEX_W +: TEX_W] == e, "R7", $sformatf("lane %0d held", i),
          int'(out_texel[i*TEX_W +: TEX_W]), int'(e));
    end
  endtask

  task automatic set_lane(int i, int l, int u, int v);
    g_lod[i] = LOD_W'(l); g_u[i] = U_W'(u); g_v[i] = V_W'(v);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1 && rd_en == 0 && out_done == 0, "R1", "reset handshake", int'({in_ready, rd_en, out_done}), 4);
    chk(out_cycles == 0 && out_texel == '0, "R1", "reset outputs", int'(out_cycles), 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && rd_en == 0 && out_done == 0, "R1", "after reset release", int'({in_ready, rd_en, out_done}), 4);
    void'($urandom(32'd4711));

    // R3: one coherent tile
    set_lane(0, 2, 8'h40, 8'h80); set_lane(1, 2, 8'h41, 8'h80);
    set_lane(2, 2, 8'h40, 8'h81); set_lane(3, 2, 8'h43, 8'h83);
    run_group(0);
    // R3/R4: four distinct tiles
    set_lane(0, 1, 8'h10, 8'h20); set_lane(1, 1, 8'h94, 8'h20);
    set_lane(2, 1, 8'h10, 8'hA5); set_lane(3, 7, 8'hFF, 8'h03);
    run_group(0);
    // R9: lod differs only
    set_lane(0, 0, 8'h21, 8'h31); set_lane(1, 3, 8'h21, 8'h31);
    set_lane(2, 0, 8'h22, 8'h32); set_lane(3, 3, 8'h20, 8'h30);
    run_group(0);
    // R4: interleaved sharing lanes 0/2 and 1/3
    set_lane(0, 5, 8'h04, 8'h08); set_lane(1, 5, 8'h60, 8'h08);
    set_lane(2, 5, 8'h07, 8'h0B); set_lane(3, 5, 8'h62, 8'h09);
    run_group(0);
    // R10: junk offered while busy
    set_lane(0, 4, 8'h00, 8'h00); set_lane(1, 4, 8'h00, 8'h00);
    set_lane(2, 4, 8'h00, 8'h00); set_lane(3, 9, 8'h33, 8'h77);
    run_group(1);

    for (int k = 0; k < 300; k++) begin
      int mode = $urandom_range(0, 2);
      logic [LOD_W-1:0] bl [2];
      logic [U_W-1:0] bu [2];
      logic [V_W-1:0] bv [2];
      for (int b = 0; b < 2; b++) begin
        bl[b] = LOD_W'($urandom); bu[b] = U_W'($urandom); bv[b] = V_W'($urandom);
      end
      for (int i = 0; i < 4; i++) begin
        int b = (mode == 0) ? 0 : $urandom_range(0, 1);
        if (mode == 1) begin
          set_lane(i, $urandom, $urandom, $urandom);
        end else begin
          g_lod[i] = bl[b];
          g_u[i] = {bu[b][U_W-1:2], 2'($urandom)};
          g_v[i] = {bv[b][V_W-1:2], 2'($urandom)};
        end
      end
      run_group(k % 7 == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule